// File: doc/BRIEF.md
# Single and Double-Precision Shift Unit

This block shifts an 8, 16 or 32-bit destination operand left or right. It offers a logical left shift, a logical right shift and an arithmetic right shift. It also offers two funnel shifts for 16 and 32-bit operands. In a funnel shift, the bits that leave the destination are replaced from the adjacent end of a second source operand. The shift count comes either from an immediate field or from a count register, and only its low five bits are used.

Besides the shifted value, the unit produces carry, sign, zero and parity flags. Each flag has an update-mask bit, which tells the flag logic downstream whether to write it. A flag that the operation leaves undefined is driven to 0, and its mask bit is cleared.

The datapath is combinational. A parameter can place one register stage on the outputs. In that case results appear one clock after the request, qualified by a valid strobe.

Top module: `dual_shifter`

## Requirements
- R1: With `op`=0 (logical left; codes 5 to 7 act the same), the result is the operand shifted left with zeros entering at bit 0, and `cf_o` is the last bit that left bit W-1.
- R2: With `op`=1 (logical right), zeros enter at bit W-1, and `cf_o` is the last bit that left bit 0.
- R3: With `op`=2 (arithmetic right), the sign bit W-1 is replicated into the vacated bits, so the result rounds toward minus infinity. `cf_o` is the last bit that left bit 0.
- R4: The effective count is the selected count modulo 32. The count register is used when `cnt_sel_i`=1 and the immediate otherwise.
- R5: With `op`=3 (funnel left) and a width of 16 or 32, the vacated low bits are filled from the top of `src_i`. `cf_o` is the last bit that left the destination.
- R6: With `op`=4 (funnel right) and a width of 16 or 32, the vacated high bits are filled from the bottom of `src_i`. `cf_o` is the last bit that left bit 0.
- R7: For a defined operation with a nonzero count, the flags are set from the result:
  - `sf_o` is bit W-1.
  - `zf_o` is 1 when the result is zero.
  - `pf_o` is 1 when the low byte holds an even number of ones.
  - `flag_upd_o` bits are [0]=carry, [1]=sign, [2]=zero, [3]=parity, and all four are 1.
- R8: An effective count of zero returns the operand unchanged, with all flags at 0, `flag_upd_o`=0 and `undef_o`=0.
- R9: A 16-bit funnel shift with an effective count of 17 to 31 raises `undef_o`. The result is the window of the pattern {dst,src,dst}: bits 47:32 after a left shift, or bits 15:0 after a right shift. All flags are 0 and `flag_upd_o`=0.
- R10: A funnel shift with `size_i`=0 (8 bits) raises `undef_o`, returns the operand unchanged, and drives all flags and mask bits to 0.
- R11: A single shift whose effective count exceeds the width gives 0, or the sign fill for the arithmetic right shift. In that case `cf_o`=0 and `flag_upd_o`[0]=0, while the other three flags are still updated.
- R12: With the output register enabled, `out_valid_o` equals `in_valid_i` delayed by one clock, and all outputs are zero in reset.
- R13: Result bits at and above the selected width are 0. The width codes are `size_i` 0=8, 1=16, 2 or 3=32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Operand width code |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Second source for funnel shifts |
| cnt_imm_i | input | 8 | Immediate count |
| cnt_reg_i | input | 8 | Count register value |
| cnt_sel_i | input | 1 | 1 selects the count register |
| out_valid_o | output | 1 | Result strobe |
| result_o | output | 32 | Shifted value, zero-extended |
| cf_o | output | 1 | Carry flag |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| pf_o | output | 1 | Parity flag |
| flag_upd_o | output | 4 | Per-flag update mask |
| undef_o | output | 1 | Undefined-result indicator |

## Verification
The bound checker watches several properties on every clock:
- the one-cycle valid delay;
- zero-extension above the byte width;
- that undefined results never carry flag updates;
- that a cleared carry mask means a zero carry;
- consistency of the zero flag with the result;
- that `undef_o` appears only for funnel requests;
- pass-through on a zero count.

The bit-exact values need the bench's one-bit-per-step reference. These are funnel fills, carry as the last bit out, sign fill toward minus infinity, modulo-32 wrap of register counts, and the deterministic {dst,src,dst} window for over-long 16-bit funnels. The bench runs directed corner cases and a long random mix.

// File: rtl/dsh_pkg.sv
package dsh_pkg;
   typedef enum logic [2:0] {
      OP_SHL  = 3'd0,
      OP_SHR  = 3'd1,
      OP_SAR  = 3'd2,
      OP_DSHL = 3'd3,
      OP_DSHR = 3'd4
   } dsh_op_e;

   localparam int FB_CF = 0;
   localparam int FB_SF = 1;
   localparam int FB_ZF = 2;
   localparam int FB_PF = 3;
   localparam int FLAG_N = 4;

   function automatic logic [6:0] width_of(input logic [1:0] sz);
      case (sz)
         2'd0:    width_of = 7'd8;
         2'd1:    width_of = 7'd16;
         default: width_of = 7'd32;
      endcase
   endfunction
endpackage

// File: rtl/dsh_count_sel.sv
module dsh_count_sel #(
   parameter int CNT_W = 8,
   parameter int N_W   = 5
) (
   input  logic             sel_reg,
   input  logic [CNT_W-1:0] imm,
   input  logic [CNT_W-1:0] creg,
   output logic [N_W-1:0]   n,
   output logic             n_zero
);
   if (CNT_W < N_W) begin : g_bad_cnt
      $error("count field narrower than modulo field");
   end

   logic [CNT_W-1:0] raw;

   always_comb begin
      raw    = sel_reg ? creg : imm;
      n      = raw[N_W-1:0];
      n_zero = (n == '0);
   end
endmodule

// File: rtl/dsh_core.sv
module dsh_core import dsh_pkg::*; #(
   parameter int DATA_W = 32,
   parameter int N_W    = 5
) (
   input  logic [2:0]        op,
   input  logic [1:0]        size,
   input  logic [N_W-1:0]    n,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   output logic [DATA_W-1:0] res,
   output logic              cf,
   output logic              cf_def,
   output logic              undef
);
   localparam int SW = 2 * DATA_W;
   localparam int XW = 3 * DATA_W + 1;

   logic [6:0]        w;
   int                wi;
   logic [DATA_W-1:0] wmask, a, b, a_sx;
   logic [SW-1:0]     sl, sr, sa;
   logic [XW-1:0]     x, xl, xr;

   always_comb begin
      w     = width_of(size);
      wi    = int'(w);
      wmask = ~({DATA_W{1'b1}} << w);
      a     = a_in & wmask;
      b     = b_in & wmask;
      a_sx  = a[wi-1] ? (a | ~wmask) : a;
      x     = XW'(a) | (XW'(b) << w) | (XW'(a) << (2 * wi));
      sl    = SW'(a) << n;
      sr    = {a, {DATA_W{1'b0}}} >> n;
      sa    = SW'($signed({a_sx, {DATA_W{1'b0}}}) >>> n);
      xl    = x << n;
      xr    = {x[XW-2:0], 1'b0} >> n;
      res    = '0;
      cf     = 1'b0;
      cf_def = 1'b0;
      undef  = 1'b0;
      case (dsh_op_e'(op))
         OP_SHR: begin
            res    = sr[SW-1:DATA_W];
            cf     = sr[DATA_W-1];
            cf_def = (7'(n) <= w);
         end
         OP_SAR: begin
            res    = sa[SW-1:DATA_W] & wmask;
            cf     = sa[DATA_W-1];
            cf_def = (7'(n) <= w);
         end
         OP_DSHL: begin
            if (size == 2'd0) begin
               res   = a;
               undef = 1'b1;
            end else begin
               res    = DATA_W'(xl >> (2 * wi)) & wmask;
               cf     = xl[3 * wi];
               cf_def = 1'b1;
               undef  = (size == 2'd1) && (n > N_W'(16));
            end
         end
         OP_DSHR: begin
            if (size == 2'd0) begin
               res   = a;
               undef = 1'b1;
            end else begin
               res    = xr[DATA_W:1] & wmask;
               cf     = xr[0];
               cf_def = 1'b1;
               undef  = (size == 2'd1) && (n > N_W'(16));
            end
         end
         default: begin
            res    = sl[DATA_W-1:0] & wmask;
            cf     = sl[wi];
            cf_def = (7'(n) <= w);
         end
      endcase
      if (n == '0) begin
         res    = a;
         cf     = 1'b0;
         cf_def = 1'b0;
         undef  = 1'b0;
      end
   end
endmodule

// File: rtl/dsh_flags.sv
module dsh_flags import dsh_pkg::*; #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] res,
   input  logic [1:0]        size,
   input  logic              n_zero,
   input  logic              undef,
   input  logic              cf_in,
   input  logic              cf_def,
   output logic              cf,
   output logic              sf,
   output logic              zf,
   output logic              pf,
   output logic [FLAG_N-1:0] upd
);
   int wi;

   always_comb begin
      wi  = int'(width_of(size));
      cf  = 1'b0;
      sf  = 1'b0;
      zf  = 1'b0;
      pf  = 1'b0;
      upd = '0;
      if (!n_zero && !undef) begin
         sf         = res[wi-1];
         zf         = (res == '0);
         pf         = ~^res[7:0];
         cf         = cf_def & cf_in;
         upd[FB_SF] = 1'b1;
         upd[FB_ZF] = 1'b1;
         upd[FB_PF] = 1'b1;
         upd[FB_CF] = cf_def;
      end
   end
endmodule

// File: rtl/dual_shifter.sv
module dual_shifter import dsh_pkg::*; #(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid_i,
   input  logic [2:0]        op_i,
   input  logic [1:0]        size_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [CNT_W-1:0]  cnt_imm_i,
   input  logic [CNT_W-1:0]  cnt_reg_i,
   input  logic              cnt_sel_i,
   output logic              out_valid_o,
   output logic [DATA_W-1:0] result_o,
   output logic              cf_o,
   output logic              sf_o,
   output logic              zf_o,
   output logic              pf_o,
   output logic [3:0]        flag_upd_o,
   output logic              undef_o
);
   localparam int N_W = $clog2(DATA_W);

   if (DATA_W != 32) begin : g_bad_width
      $error("operand width must be 32");
   end

   logic [N_W-1:0]    n;
   logic              n_zero;
   logic [DATA_W-1:0] res_c;
   logic              cf_raw, cf_def, undef_c;
   logic              cf_c, sf_c, zf_c, pf_c;
   logic [3:0]        upd_c;

   dsh_count_sel #(.CNT_W(CNT_W), .N_W(N_W)) u_cnt (
      .sel_reg (cnt_sel_i),
      .imm     (cnt_imm_i),
      .creg    (cnt_reg_i),
      .n       (n),
      .n_zero  (n_zero)
   );

   dsh_core #(.DATA_W(DATA_W), .N_W(N_W)) u_core (
      .op     (op_i),
      .size   (size_i),
      .n      (n),
      .a_in   (dst_i),
      .b_in   (src_i),
      .res    (res_c),
      .cf     (cf_raw),
      .cf_def (cf_def),
      .undef  (undef_c)
   );

   dsh_flags #(.DATA_W(DATA_W)) u_flags (
      .res    (res_c),
      .size   (size_i),
      .n_zero (n_zero),
      .undef  (undef_c),
      .cf_in  (cf_raw),
      .cf_def (cf_def),
      .cf     (cf_c),
      .sf     (sf_c),
      .zf     (zf_c),
      .pf     (pf_c),
      .upd    (upd_c)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid_o <= 1'b0;
            result_o    <= '0;
            cf_o        <= 1'b0;
            sf_o        <= 1'b0;
            zf_o        <= 1'b0;
            pf_o        <= 1'b0;
            flag_upd_o  <= '0;
            undef_o     <= 1'b0;
         end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
               result_o   <= res_c;
               cf_o       <= cf_c;
               sf_o       <= sf_c;
               zf_o       <= zf_c;
               pf_o       <= pf_c;
               flag_upd_o <= upd_c;
               undef_o    <= undef_c;
            end
         end
      end
   end else begin : g_comb
      always_comb begin
         out_valid_o = in_valid_i;
         result_o    = res_c;
         cf_o        = cf_c;
         sf_o        = sf_c;
         zf_o        = zf_c;
         pf_o        = pf_c;
         flag_upd_o  = upd_c;
         undef_o     = undef_c;
      end
   end
endmodule

// File: rtl/dual_shifter_chk.sv
module dual_shifter_chk #(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid_i,
   input logic [2:0]        op_i,
   input logic [1:0]        size_i,
   input logic [DATA_W-1:0] dst_i,
   input logic [DATA_W-1:0] src_i,
   input logic [CNT_W-1:0]  cnt_imm_i,
   input logic [CNT_W-1:0]  cnt_reg_i,
   input logic              cnt_sel_i,
   input logic              out_valid_o,
   input logic [DATA_W-1:0] result_o,
   input logic              cf_o,
   input logic              sf_o,
   input logic              zf_o,
   input logic              pf_o,
   input logic [3:0]        flag_upd_o,
   input logic              undef_o
);
   logic [4:0] eff_cnt;
   assign eff_cnt = cnt_sel_i ? cnt_reg_i[4:0] : cnt_imm_i[4:0];

   AST_UNDEF_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      undef_o |-> (flag_upd_o == 4'b0 && !cf_o && !sf_o && !zf_o && !pf_o)); // R9
   AST_CF_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_upd_o[0] |-> !cf_o); // R11
   AST_ZF_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      flag_upd_o[2] |-> (zf_o == (result_o == '0))); // R7

   if (REG_OUT) begin : g_seq
      AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid_o == $past(in_valid_i)); // R12
      AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         $past(in_valid_i && size_i == 2'd0) |-> result_o[DATA_W-1:8] == '0); // R13
      AST_UNDEF_ONLY_FUNNEL: assert property (@(posedge clk) disable iff (!rst_n)
         $past(in_valid_i && op_i < 3'd3) |-> !undef_o); // R10
      AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         $past(in_valid_i && eff_cnt == 5'd0 && size_i == 2'd2)
            |-> (result_o == $past(dst_i) && flag_upd_o == 4'b0)); // R8
   end
endmodule

bind dual_shifter dual_shifter_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sim_dual_shifter.sv
module sim_dual_shifter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid_i = 1'b0;
   logic [2:0]  op_i = '0;
   logic [1:0]  size_i = '0;
   logic [31:0] dst_i = '0, src_i = '0;
   logic [7:0]  cnt_imm_i = '0, cnt_reg_i = '0;
   logic        cnt_sel_i = 1'b0;
   logic        out_valid_o, cf_o, sf_o, zf_o, pf_o, undef_o;
   logic [31:0] result_o;
   logic [3:0]  flag_upd_o;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   dual_shifter u0 (.*);

   // expected values of the request in flight
   logic        e_pend = 1'b0;
   logic        e_valid = 1'b0;
   logic [31:0] e_res, e_mask;
   logic        e_cf, e_sf, e_zf, e_pf, e_undef;
   logic [3:0]  e_upd;
   string       e_tag, e_ftag;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model(input logic [2:0] op, input logic [1:0] sz,
                        input logic [31:0] dst, input logic [31:0] src, input int n);
      int w;
      logic [31:0] m, d, s, t;
      logic c, cdef, sgn;
      w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
      m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
      d = dst & m; s = src & m; t = dst & m;
      c = 0; cdef = 1; e_undef = 0; e_mask = m;
      e_tag = (op == 1) ? "R2" : (op == 2) ? "R3" : (op == 3) ? "R5" : (op == 4) ? "R6" : "R1";
      e_ftag = "R7";
      if (n == 0) begin
         e_res = d; e_tag = "R8"; e_ftag = "R8";
         e_cf = 0; e_sf = 0; e_zf = 0; e_pf = 0; e_upd = 0;
         return;
      end
      if ((op == 3 || op == 4) && w == 8) begin
         e_res = d; e_undef = 1; e_tag = "R10"; e_ftag = "R10";
         e_cf = 0; e_sf = 0; e_zf = 0; e_pf = 0; e_upd = 0;
         return;
      end
      for (int i = 0; i < n; i++) begin
         case (op)
            3'd1: begin c = d[0]; d = d >> 1; end
            3'd2: begin c = d[0]; sgn = d[w-1]; d = (d >> 1) | ({31'b0, sgn} << (w - 1)); end
            3'd3: begin
               c = d[w-1];
               d = ((d << 1) | {31'b0, s[w-1]}) & m;
               s = ((s << 1) | {31'b0, t[w-1]}) & m;
               t = (t << 1) & m;
            end
            3'd4: begin
               c = d[0];
               d = (d >> 1) | ({31'b0, s[0]} << (w - 1));
               s = (s >> 1) | ({31'b0, t[0]} << (w - 1));
               t = t >> 1;
            end
            default: begin c = d[w-1]; d = (d << 1) & m; end
         endcase
      end
      e_res = d;
      if (op < 3 || op > 4) begin
         if (n > w) begin cdef = 0; e_tag = "R11"; e_ftag = "R11"; end
      end else if (w == 16 && n > 16) begin
         e_undef = 1; e_tag = "R9"; e_ftag = "R9";
         e_cf = 0; e_sf = 0; e_zf = 0; e_pf = 0; e_upd = 0;
         return;
      end
      e_cf  = cdef ? c : 1'b0;
      e_sf  = d[w-1];
      e_zf  = (d == 0);
      e_pf  = ~^d[7:0];
      e_upd = cdef ? 4'b1111 : 4'b1110;
   endtask

   task automatic compare_out();
      if (!e_pend) return;
      chk("R12 out_valid", {31'b0, out_valid_o}, {31'b0, e_valid});
      if (e_valid) begin
         chk({e_tag, " result"}, result_o, e_res);
         chk("R13 upper bits", result_o & ~e_mask, 32'd0);
         chk({e_ftag, " flags"}, {27'b0, flag_upd_o, cf_o}, {27'b0, e_upd, e_cf});
         chk({e_ftag, " sf/zf/pf"}, {29'b0, sf_o, zf_o, pf_o}, {29'b0, e_sf, e_zf, e_pf});
         chk({e_tag, " undef"}, {31'b0, undef_o}, {31'b0, e_undef});
      end
   endtask

   task automatic step(input logic v, input logic [2:0] op, input logic [1:0] sz,
                       input logic [31:0] dst, input logic [31:0] src,
                       input logic sel, input logic [7:0] imm, input logic [7:0] creg);
      @(negedge clk);
      compare_out();
      in_valid_i = v; op_i = op; size_i = sz; dst_i = dst; src_i = src;
      cnt_sel_i = sel; cnt_imm_i = imm; cnt_reg_i = creg;
      e_valid = v;
      e_pend = 1'b1;
      if (v) begin
         model(op, sz, dst, src, int'(sel ? creg[4:0] : imm[4:0]));
         if (sel && creg > 8'd31) e_tag = {e_tag, "/R4"};
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk("R12 reset valid", {31'b0, out_valid_o}, 32'd0);
      chk("R12 reset result", result_o, 32'd0);
      chk("R12 reset mask", {28'b0, flag_upd_o}, 32'd0);
      rst_n = 1'b1;
      // directed corners
      step(1, 3'd0, 2'd0, 32'h81, 0, 0, 8'd1, 0);                 // R1 carry out of bit 7
      step(1, 3'd2, 2'd0, 32'h80, 0, 0, 8'd3, 0);                 // R3 sign fill
      step(1, 3'd1, 2'd1, 32'h8001, 0, 0, 8'd1, 0);               // R2
      step(1, 3'd3, 2'd1, 32'h1234, 32'hABCD, 0, 8'd4, 0);        // R5
      step(1, 3'd4, 2'd2, 32'h1234_5678, 32'h9ABC_DEF0, 0, 8'd8, 0); // R6
      step(1, 3'd0, 2'd2, 32'h4000_0001, 0, 1, 8'd0, 8'd33);      // R4 wrap to 1
      step(1, 3'd2, 2'd2, 32'h8000_0000, 0, 1, 8'd99, 8'd224);    // R4 wrap to 0 -> R8
      step(1, 3'd1, 2'd2, 32'hDEAD_BEEF, 0, 0, 8'd32, 0);         // R8
      step(1, 3'd3, 2'd1, 32'h1234, 32'hABCD, 0, 8'd20, 0);       // R9
      step(1, 3'd4, 2'd1, 32'h1234, 32'hABCD, 0, 8'd31, 0);       // R9
      step(1, 3'd3, 2'd0, 32'h5A, 32'hC3, 0, 8'd3, 0);            // R10
      step(1, 3'd0, 2'd0, 32'hFF, 0, 0, 8'd9, 0);                 // R11
      step(1, 3'd2, 2'd0, 32'h90, 0, 0, 8'd12, 0);                // R11 sign
      step(1, 3'd3, 2'd1, 32'h8001, 32'h00FF, 0, 8'd16, 0);       // R5 full count
      step(0, 3'd0, 2'd0, 0, 0, 0, 8'd0, 0);                      // R12 idle
      step(1, 3'd0, 2'd0, 32'hFFFF_FF01, 0, 0, 8'd1, 0);          // R13
      for (int i = 0; i < 3000; i++) begin
         step(($urandom % 8) != 0, 3'($urandom % 5), 2'($urandom % 4),
              $urandom, $urandom, 1'($urandom), 8'($urandom), 8'($urandom));
      end
      step(0, 3'd0, 2'd0, 0, 0, 0, 8'd0, 0);
      @(negedge clk);
      compare_out();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule